// File: doc/BRIEF.md
# Down-Counting Raster Timing Generator

This block produces the line and frame timing for a video raster. It has two down counters. The horizontal counter runs on every pixel clock. The vertical counter takes one step each time the horizontal counter wraps. Each counter is compared against four programmable windows: sync, blank, pixel-data enable and pixel-clock enable. The horizontal and vertical results are then merged into five registered strobes. Each strobe passes through its own short delay line, which stands in for the internal path delays that software compensates with fixed offsets in the programmed window values.

Software supplies the line total, the frame total and a start/stop pair for each window on each axis. A window is open only while its counter is strictly below the start value and strictly above the stop value. All programmed values are captured into shadow registers at the frame wrap, so a change made mid-frame never tears the raster.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal counter counts down one per clock from the captured line total to 0 and then reloads, so a line lasts line total + 1 clocks.
- R2: The vertical counter moves down by one only on the clock where the horizontal counter is 0, and reloads from the frame total after 0, so a frame lasts (frame total + 1) lines.
- R3: `hsync_o` reflects horizontal window 0 (sync): high while start > horizontal count > stop.
- R4: `vsync_o` reflects vertical window 0 (sync) with the same exclusive comparison against the vertical count.
- R5: `blank_o` is high when either the horizontal or the vertical window 1 (blank) is open.
- R6: `pix_oe_o` is high only when both the horizontal and the vertical window 2 (active) are open.
- R7: `pix_ce_o` is high only when both the horizontal and the vertical window 3 (pixel clock) are open.
- R8: A synchronous active-high reset loads both counters from the live totals, captures all live settings, and drives every output low at the following clock edge.
- R9: Changes to totals or windows have no effect until the clock edge where both counters are 0 (frame wrap), where all of them are captured together.
- R10: With default parameters, sync outputs follow the counter state by 1 clock, blank and pixel output enable by 2 clocks, and pixel clock enable by 7 clocks; with the fractional-pixel option set, pixel output enable has the sync latency.
- R11: A window whose start is not greater than its stop + 1 never opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| h_total_i | input | HW | Line total (line length minus one) |
| v_total_i | input | VW | Frame total (line count minus one) |
| h_start_i | input | NWIN x HW | Horizontal window starts (index 0 sync, 1 blank, 2 active, 3 pixel clock) |
| h_stop_i | input | NWIN x HW | Horizontal window stops, same indexing |
| v_start_i | input | NWIN x VW | Vertical window starts, same indexing |
| v_stop_i | input | NWIN x VW | Vertical window stops, same indexing |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| blank_o | output | 1 | Blanking |
| pix_oe_o | output | 1 | Pixel output enable |
| pix_ce_o | output | 1 | Pixel clock enable |

## Verification
The hardest case to reach from the ports is a register write landing partway through a frame, where the old line length and the old windows must stay in force until the frame wrap. The stimulus runs the raster, waits for a vertical sync edge, rewrites the line total and windows a few clocks later, and measures the hsync period before and after the wrap. Randomised rounds also rewrite all settings at random clocks, and the reference model checks every output on every clock. A frame of four lines and a mid-run reset exercise the reload paths.

// File: rtl/raster_pkg.sv
package raster_pkg;

   localparam int NWIN      = 4;
   localparam int WIN_SYNC  = 0;
   localparam int WIN_BLANK = 1;
   localparam int WIN_ACT   = 2;
   localparam int WIN_PCLK  = 3;

   localparam int NOUT       = 5;
   localparam int OUT_HSYNC  = 0;
   localparam int OUT_VSYNC  = 1;
   localparam int OUT_BLANK  = 2;
   localparam int OUT_PIXOE  = 3;
   localparam int OUT_PIXCE  = 4;

   localparam int MAX_DEPTH  = 16;

   typedef enum logic [1:0] {
      MRG_H_ONLY,
      MRG_V_ONLY,
      MRG_EITHER,
      MRG_BOTH
   } merge_e;

   function automatic logic merge_hits(merge_e m, logic h, logic v);
      case (m)
         MRG_H_ONLY: return h;
         MRG_V_ONLY: return v;
         MRG_EITHER: return h | v;
         default:    return h & v;
      endcase
   endfunction

endpackage

// File: rtl/raster_dcnt.sv
module raster_dcnt #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step_i,
   input  logic [W-1:0] rst_val_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] cnt_o,
   output logic         zero_o
);

   generate
      if (W < 2) begin : g_bad_width
         $error("raster_dcnt: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= rst_val_i;
      end else if (step_i) begin
         if (cnt_q == '0) cnt_q <= load_val_i;
         else             cnt_q <= cnt_q - W'(1);
      end
   end

   assign cnt_o  = cnt_q;
   assign zero_o = (cnt_q == '0);

   // R1 R2: a wrap takes the reload value presented on that edge
   a_r2_reload: assert property (@(posedge clk) disable iff (rst)
      (step_i && zero_o) |=> (cnt_o == $past(load_val_i)));

   // R1 R2: without a step the count holds
   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      (!step_i) |=> $stable(cnt_o));

endmodule

// File: rtl/raster_win.sv
module raster_win #(
   parameter int W = 11,
   parameter int N = 4
) (
   input  logic [W-1:0]        cnt_i,
   input  logic [N-1:0][W-1:0] start_i,
   input  logic [N-1:0][W-1:0] stop_i,
   output logic [N-1:0]        hit_o
);

   generate
      if (N < 1) begin : g_bad_count
         $error("raster_win: N must be positive");
      end
      for (genvar i = 0; i < N; i++) begin : g_cmp
         logic below_start;
         logic above_stop;
         assign below_start = (cnt_i < start_i[i]);
         assign above_stop  = (cnt_i > stop_i[i]);
         assign hit_o[i]    = below_start & above_stop;
      end
   endgenerate

endmodule

// File: rtl/raster_pipe.sv
module raster_pipe #(
   parameter int DEPTH = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);

   generate
      if (DEPTH < 1 || DEPTH > raster_pkg::MAX_DEPTH) begin : g_bad_depth
         $error("raster_pipe: DEPTH out of range");
      end

      if (DEPTH == 1) begin : g_single
         logic q;
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [DEPTH-1:0] sr;
         always_ff @(posedge clk) begin
            if (rst) sr <= '0;
            else     sr <= {sr[DEPTH-2:0], din};
         end
         assign dout = sr[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import raster_pkg::*;
#(
   parameter int HW         = 11,
   parameter int VW         = 11,
   parameter int SYNC_DLY   = 0,
   parameter int BLANK_DLY  = 1,
   parameter int ACT_DLY    = 1,
   parameter int PCLK_DLY   = 6,
   parameter bit FRAC_PIXEL = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [HW-1:0]        h_total_i,
   input  logic [VW-1:0]        v_total_i,
   input  logic [NWIN-1:0][HW-1:0] h_start_i,
   input  logic [NWIN-1:0][HW-1:0] h_stop_i,
   input  logic [NWIN-1:0][VW-1:0] v_start_i,
   input  logic [NWIN-1:0][VW-1:0] v_stop_i,
   output logic                 hsync_o,
   output logic                 vsync_o,
   output logic                 blank_o,
   output logic                 pix_oe_o,
   output logic                 pix_ce_o
);

   localparam int ACT_EFF = FRAC_PIXEL ? SYNC_DLY : ACT_DLY;

   generate
      if (HW < 2 || VW < 2) begin : g_bad_width
         $error("raster_timing_gen: counter widths must be at least 2");
      end
      if (SYNC_DLY < 0 || BLANK_DLY < 0 || ACT_DLY < 0 || PCLK_DLY < 0) begin : g_bad_dly
         $error("raster_timing_gen: delays must not be negative");
      end
   endgenerate

   function automatic int extra_dly(int k);
      case (k)
         OUT_HSYNC, OUT_VSYNC: return SYNC_DLY;
         OUT_BLANK:            return BLANK_DLY;
         OUT_PIXOE:            return ACT_EFF;
         default:              return PCLK_DLY;
      endcase
   endfunction

   function automatic int win_of(int k);
      case (k)
         OUT_HSYNC, OUT_VSYNC: return WIN_SYNC;
         OUT_BLANK:            return WIN_BLANK;
         OUT_PIXOE:            return WIN_ACT;
         default:              return WIN_PCLK;
      endcase
   endfunction

   function automatic merge_e mode_of(int k);
      case (k)
         OUT_HSYNC: return MRG_H_ONLY;
         OUT_VSYNC: return MRG_V_ONLY;
         OUT_BLANK: return MRG_EITHER;
         default:   return MRG_BOTH;
      endcase
   endfunction

   // shadow copies, captured at reset and at each frame wrap
   logic [HW-1:0]           htot_q;
   logic [NWIN-1:0][HW-1:0] hsta_q, hsto_q;
   logic [NWIN-1:0][VW-1:0] vsta_q, vsto_q;

   logic [HW-1:0] hcnt;
   logic [VW-1:0] vcnt;
   logic          h_zero, v_zero, frame_wrap;
   logic [HW-1:0] h_reload;

   assign frame_wrap = h_zero & v_zero;
   assign h_reload   = frame_wrap ? h_total_i : htot_q;

   always_ff @(posedge clk) begin
      if (rst || frame_wrap) begin
         htot_q <= h_total_i;
         hsta_q <= h_start_i;
         hsto_q <= h_stop_i;
         vsta_q <= v_start_i;
         vsto_q <= v_stop_i;
      end
   end

   raster_dcnt #(.W(HW)) u_hcnt (
      .clk        (clk),
      .rst        (rst),
      .step_i     (1'b1),
      .rst_val_i  (h_total_i),
      .load_val_i (h_reload),
      .cnt_o      (hcnt),
      .zero_o     (h_zero)
   );

   raster_dcnt #(.W(VW)) u_vcnt (
      .clk        (clk),
      .rst        (rst),
      .step_i     (h_zero),
      .rst_val_i  (v_total_i),
      .load_val_i (v_total_i),
      .cnt_o      (vcnt),
      .zero_o     (v_zero)
   );

   logic [NWIN-1:0] h_hit, v_hit;

   raster_win #(.W(HW), .N(NWIN)) u_hwin (
      .cnt_i   (hcnt),
      .start_i (hsta_q),
      .stop_i  (hsto_q),
      .hit_o   (h_hit)
   );

   raster_win #(.W(VW), .N(NWIN)) u_vwin (
      .cnt_i   (vcnt),
      .start_i (vsta_q),
      .stop_i  (vsto_q),
      .hit_o   (v_hit)
   );

   logic [NOUT-1:0] raw, out_q;

   generate
      for (genvar k = 0; k < NOUT; k++) begin : g_out
         localparam int     WIX   = win_of(k);
         localparam merge_e MODE  = mode_of(k);
         localparam int     DEPTH = extra_dly(k) + 1;

         assign raw[k] = merge_hits(MODE, h_hit[WIX], v_hit[WIX]);

         raster_pipe #(.DEPTH(DEPTH)) u_pipe (
            .clk  (clk),
            .rst  (rst),
            .din  (raw[k]),
            .dout (out_q[k])
         );
      end
   endgenerate

   assign hsync_o  = out_q[OUT_HSYNC];
   assign vsync_o  = out_q[OUT_VSYNC];
   assign blank_o  = out_q[OUT_BLANK];
   assign pix_oe_o = out_q[OUT_PIXOE];
   assign pix_ce_o = out_q[OUT_PIXCE];

   // R1: horizontal count falls by one on every non-zero clock
   a_r1_hstep: assert property (@(posedge clk) disable iff (rst)
      (hcnt != '0) |=> (hcnt == $past(hcnt) - 1'b1));

   // R2: vertical count only moves on the horizontal wrap
   a_r2_vstep: assert property (@(posedge clk) disable iff (rst)
      (h_zero && !v_zero) |=> (vcnt == $past(vcnt) - 1'b1));

   // R8: reset clears every output on the next edge
   a_r8_reset_quiet: assert property (@(posedge clk)
      rst |=> (!hsync_o && !vsync_o && !blank_o && !pix_oe_o && !pix_ce_o));

   // R9: settings frozen between frame wraps
   a_r9_shadow_hold: assert property (@(posedge clk) disable iff (rst)
      (!frame_wrap) |=> ($stable(htot_q) && $stable(hsta_q) && $stable(hsto_q)
                         && $stable(vsta_q) && $stable(vsto_q)));

   // R3: sync output lags its window decision by the sync path depth (default 1)
   a_r3_hsync_lat: assert property (@(posedge clk) disable iff (rst)
      (SYNC_DLY == 0 && !h_hit[WIN_SYNC]) |=> !hsync_o);

endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;

   localparam int HW = 11;
   localparam int VW = 11;
   localparam int NW = 4;
   localparam int D_SYNC = 0, D_BLANK = 1, D_ACT = 1, D_PCLK = 6;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst;
   logic [HW-1:0] ht;
   logic [VW-1:0] vt;
   logic [NW-1:0][HW-1:0] hsa, hso;
   logic [NW-1:0][VW-1:0] vsa, vso;
   logic hsync, vsync, blank, pix_oe, pix_ce;

   raster_timing_gen u0 (
      .clk(clk), .rst(rst),
      .h_total_i(ht), .v_total_i(vt),
      .h_start_i(hsa), .h_stop_i(hso),
      .v_start_i(vsa), .v_stop_i(vso),
      .hsync_o(hsync), .vsync_o(vsync), .blank_o(blank),
      .pix_oe_o(pix_oe), .pix_ce_o(pix_ce)
   );

   int checks = 0, errors = 0, cyc = 0;

   // reference model state
   int m_hc, m_vc, m_ht;
   int m_hsa[NW], m_hso[NW], m_vsa[NW], m_vso[NW];
   bit pipe[5][8];
   int dly[5];

   bit prev_hs, prev_vs, prev_oe;
   bit hs_rose, vs_rose, oe_rose;
   int last_hs_rise = -1, hs_period = 0;
   int last_vs_rise = -1, vs_period = 0;
   int oe_rise_cyc = 0;

   initial begin
      dly[0] = D_SYNC; dly[1] = D_SYNC; dly[2] = D_BLANK;
      dly[3] = D_ACT;  dly[4] = D_PCLK;
   end

   function automatic bit open_w(int s, int p, int c);
      return (s > c) && (c > p);
   endfunction

   task automatic capture();
      m_ht = int'(ht);
      for (int i = 0; i < NW; i++) begin
         m_hsa[i] = int'(hsa[i]); m_hso[i] = int'(hso[i]);
         m_vsa[i] = int'(vsa[i]); m_vso[i] = int'(vso[i]);
      end
   endtask

   task automatic model_step();
      bit c[5];
      if (rst) begin
         m_hc = int'(ht); m_vc = int'(vt);
         capture();
         for (int k = 0; k < 5; k++)
            for (int j = 0; j < 8; j++) pipe[k][j] = 1'b0;
      end else begin
         c[0] = open_w(m_hsa[0], m_hso[0], m_hc);
         c[1] = open_w(m_vsa[0], m_vso[0], m_vc);
         c[2] = open_w(m_hsa[1], m_hso[1], m_hc) || open_w(m_vsa[1], m_vso[1], m_vc);
         c[3] = open_w(m_hsa[2], m_hso[2], m_hc) && open_w(m_vsa[2], m_vso[2], m_vc);
         c[4] = open_w(m_hsa[3], m_hso[3], m_hc) && open_w(m_vsa[3], m_vso[3], m_vc);
         for (int k = 0; k < 5; k++) begin
            for (int j = 7; j > 0; j--) pipe[k][j] = pipe[k][j-1];
            pipe[k][0] = c[k];
         end
         if (m_hc == 0) begin
            if (m_vc == 0) begin
               m_hc = int'(ht); m_vc = int'(vt);
               capture();
            end else begin
               m_hc = m_ht; m_vc = m_vc - 1;
            end
         end else begin
            m_hc = m_hc - 1;
         end
      end
   endtask

   task automatic chk(bit act, bit exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic chk_int(int act, int exp, string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      cyc++;
      model_step();
      chk(hsync,  pipe[0][dly[0]], "R3 R1 hsync");
      chk(vsync,  pipe[1][dly[1]], "R4 R2 vsync");
      chk(blank,  pipe[2][dly[2]], "R5 R10 blank");
      chk(pix_oe, pipe[3][dly[3]], "R6 R10 pix_oe");
      chk(pix_ce, pipe[4][dly[4]], "R7 R10 pix_ce");
      hs_rose = hsync && !prev_hs;
      vs_rose = vsync && !prev_vs;
      oe_rose = pix_oe && !prev_oe;
      if (hs_rose) begin
         if (last_hs_rise >= 0) hs_period = cyc - last_hs_rise;
         last_hs_rise = cyc;
      end
      if (vs_rose) begin
         if (last_vs_rise >= 0) vs_period = cyc - last_vs_rise;
         last_vs_rise = cyc;
      end
      if (oe_rose) oe_rise_cyc = cyc;
      prev_hs = hsync; prev_vs = vsync; prev_oe = pix_oe;
   endtask

   task automatic wait_hs();
      do tick(); while (!hs_rose);
   endtask

   task automatic wait_vs();
      do tick(); while (!vs_rose);
   endtask

   task automatic do_reset(int n);
      rst = 1'b1;
      for (int i = 0; i < n; i++) tick();
      rst = 1'b0;
      last_hs_rise = -1; last_vs_rise = -1;
   endtask

   task automatic set_h(int w, int s, int p);
      hsa[w] = HW'(s); hso[w] = HW'(p);
   endtask

   task automatic set_v(int w, int s, int p);
      vsa[w] = VW'(s); vso[w] = VW'(p);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int ce_hits;
      rst = 1'b1;
      ht = HW'(19); vt = VW'(3);
      set_h(0, 18, 14); set_h(1, 19, 2); set_h(2, 16, 0); set_h(3, 20, 0);
      set_v(0, 3, 1);   set_v(1, 1, 0);  set_v(2, 4, 0);  set_v(3, 4, 0);
      do_reset(3);
      // R8: outputs quiet while reset was held
      chk(hsync | vsync | blank | pix_oe | pix_ce, 1'b0, "R8 reset outputs");

      // R1: line period is line total + 1
      wait_hs(); wait_hs();
      chk_int(hs_period, 20, "R1 line period");
      // R2: frame period is (frame total + 1) lines
      wait_vs(); wait_vs();
      chk_int(vs_period, 80, "R2 frame period");

      // R9: mid-frame rewrite must wait for the frame wrap
      for (int i = 0; i < 5; i++) tick();
      ht = HW'(9);
      set_h(0, 8, 5);
      wait_hs(); wait_hs();
      chk_int(hs_period, 20, "R9 old line period kept mid-frame");
      wait_vs(); wait_hs(); wait_hs();
      chk_int(hs_period, 10, "R9 new line period after wrap");

      // R10 R11: equal sync/active windows, empty pixel-clock window
      rst = 1'b1;
      ht = HW'(15); vt = VW'(4);
      set_h(0, 12, 6); set_h(2, 12, 6); set_h(3, 5, 4); set_h(1, 3, 0);
      set_v(0, 2, 0);  set_v(2, 5, 0);  set_v(3, 5, 0); set_v(1, 1, 0);
      do_reset(2);
      ce_hits = 0;
      for (int i = 0; i < 200; i++) begin
         tick();
         if (pix_ce) ce_hits++;
         if (oe_rose && i > 20) begin
            chk_int(oe_rise_cyc - last_hs_rise, D_ACT - D_SYNC, "R10 active lag behind sync");
         end
      end
      chk_int(ce_hits, 0, "R11 empty window never opens");

      // R8: reset mid-run
      rst = 1'b1; tick();
      chk(hsync | vsync | blank | pix_oe | pix_ce, 1'b0, "R8 mid-run reset");
      rst = 1'b0;

      // randomised rounds with rewrites at arbitrary clocks (R9 and all outputs)
      for (int r = 0; r < 8; r++) begin
         for (int i = 0; i < 600; i++) begin
            if (i % 97 == 13 + r) begin
               ht = HW'($urandom_range(30, 3));
               vt = VW'($urandom_range(6, 1));
               for (int w = 0; w < NW; w++) begin
                  set_h(w, $urandom_range(32, 0), $urandom_range(20, 0));
                  set_v(w, $urandom_range(8, 0), $urandom_range(4, 0));
               end
            end
            tick();
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule